// File: doc/BRIEF.md
# Two-Operand Integer Execute Unit

This block keeps sixteen 64-bit integer registers and runs bitwise and arithmetic operations on them. Every operation is destructive. It reads a destination register and a second operand, then writes the result back into that same destination. The second operand is either another register or a 64-bit immediate, and a flag chosen with each request selects which one. The upstream stage presents one request per cycle together with a valid strobe. The block answers with a done pulse and the written value, or with an illegal-write pulse when the request targets the hardwired-zero register.

All operations except unsigned division finish in one cycle. Division runs as a restoring divider that makes one quotient bit per cycle. While it runs, the unit raises busy and drops any new request. Division by zero is handled at once and produces an all-ones result.

Top module: `xu_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears all registers to zero and holds busy_o, done_o and illegal_o low.
- R2: Register index 0 reads as zero in every operand position.
- R3: A request with a known opcode and dst_i = 0 changes no register. One cycle after the request, illegal_o is high for one cycle and done_o stays low.
- R4: Opcode 0 is mov (dst = val), 1 is and, 2 is or and 3 is xor, each in the form dst = dst OP val.
- R5: Opcode 4 (add), 5 (sub) and 6 (mul) keep only the low 64 bits of the result and wrap silently.
- R6: Opcode 8 (inc) adds one to dst and opcode 9 (dec) subtracts one. Both ignore src_i, use_imm_i and imm_i.
- R7: When use_imm_i = 1 the second operand is imm_i. When it is 0, the second operand is register src_i.
- R8: Every accepted legal request other than a non-zero divide raises done_o in the cycle after valid_i. In that same cycle result_o shows the value written.
- R9: Opcode 7 (div) is an unsigned divide. When the divisor is non-zero, busy_o is high from the cycle after acceptance until done_o rises, exactly 64 cycles after the accepting edge. done_o stays low while busy_o is high.
- R10: A request presented while busy_o is high is ignored. It writes nothing and causes neither done_o nor illegal_o.
- R11: A divide by zero writes all ones to dst and completes like a single-cycle operation, with no busy phase.
- R12: Opcodes 10 to 15 are ignored. No register changes, and done_o and illegal_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| dst_i | input | 4 | Destination and first operand index |
| src_i | input | 4 | Second operand register index |
| use_imm_i | input | 1 | Select imm_i as the second operand |
| imm_i | input | 64 | Immediate operand |
| busy_o | output | 1 | Divide in progress; requests are dropped |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle pulse for a refused write |
| result_o | output | 64 | Value written by the completed operation |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of a divide. It must leave no trace, and a write it would have made to another register can only be seen later. The stimulus starts a 64-cycle divide and injects a mov to an untouched register partway through. After done it reads that register back with an or-with-zero, and it counts done pulses to confirm there was only one. Register contents are observed only through result_o, so the bench reads state back with non-destructive operations.

// File: rtl/xu_pkg.sv
package xu_pkg;

    localparam int XLEN = 64;
    localparam int NREG = 16;
    localparam int IDXW = $clog2(NREG);
    localparam int OPW  = 4;

    typedef enum logic [OPW-1:0] {
        OP_MOV = 4'd0,
        OP_AND = 4'd1,
        OP_OR  = 4'd2,
        OP_XOR = 4'd3,
        OP_ADD = 4'd4,
        OP_SUB = 4'd5,
        OP_MUL = 4'd6,
        OP_DIV = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9
    } xu_op_e;

    // Decoded control for one request
    typedef struct packed {
        logic accept;    // valid and not busy
        logic known;     // opcode is defined
        logic to_zero;   // destination is the hardwired-zero register
        logic is_div;
        logic div_zero;  // divisor equals zero
    } xu_ctl_t;

    function automatic logic op_known(input logic [OPW-1:0] code);
        return code <= OP_DEC;
    endfunction

endpackage

// File: rtl/xu_alu.sv
module xu_alu
    import xu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  xu_op_e       op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [2*W-1:0] prod;

    always_comb begin
        prod = a * b;
        unique case (op)
            OP_MOV:  y = b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = prod[W-1:0];
            OP_INC:  y = a + W'(1);
            OP_DEC:  y = a - W'(1);
            default: y = a;
        endcase
    end
endmodule

// File: rtl/xu_regfile.sv
module xu_regfile #(
    parameter int W  = 64,
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data
);
    logic [W-1:0] regs_q [N];
    logic [N-1:0] wsel;

    // Entry 0 never takes a write; the others decode their own enable.
    for (genvar i = 0; i < N; i++) begin : g_sel
        if (i == 0) begin : g_zero
            assign wsel[i] = 1'b0;
        end else begin : g_reg
            assign wsel[i] = we && (widx == IW'(i));
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst || i == 0)
                regs_q[i] <= '0;
            else if (wsel[i])
                regs_q[i] <= wdata;
        end
    end

    assign ra_data = (ra_idx == '0) ? '0 : regs_q[ra_idx];
    assign rb_data = (rb_idx == '0) ? '0 : regs_q[rb_idx];
endmodule

// File: rtl/xu_divider.sv
module xu_divider #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         last,
    output logic [W-1:0] quot
);
    localparam int CW = $clog2(W);

    logic [W:0]    rem_q, rem_sh, rem_nx;
    logic [W-1:0]  quo_q, quo_sh, quo_nx, dvs_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_comb begin
        rem_sh = {rem_q[W-1:0], quo_q[W-1]};
        quo_sh = {quo_q[W-2:0], 1'b0};
        if (rem_sh >= {1'b0, dvs_q}) begin
            rem_nx = rem_sh - {1'b0, dvs_q};
            quo_nx = quo_sh | W'(1);
        end else begin
            rem_nx = rem_sh;
            quo_nx = quo_sh;
        end
    end

    assign busy = busy_q;
    assign last = busy_q && (cnt_q == CW'(W-1));
    assign quot = quo_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            rem_q  <= '0;
            quo_q  <= dividend;
            dvs_q  <= divisor;
            cnt_q  <= '0;
        end else if (busy_q) begin
            rem_q <= rem_nx;
            quo_q <= quo_nx;
            cnt_q <= cnt_q + CW'(1);
            if (last)
                busy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/xu_exec_unit.sv
module xu_exec_unit
    import xu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int N  = NREG,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [3:0]    op_i,
    input  logic [IW-1:0] dst_i,
    input  logic [IW-1:0] src_i,
    input  logic          use_imm_i,
    input  logic [W-1:0]  imm_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          illegal_o,
    output logic [W-1:0]  result_o
);
    xu_ctl_t       ctl;
    logic [W-1:0]  opa, opb_reg, opb, alu_y, quick_val, div_quot, wdata;
    logic [IW-1:0] widx, pend_dst_q;
    logic          go, quick, div_start, div_busy, div_last, we;
    logic          done_q, illegal_q;
    logic [W-1:0]  result_q;

    xu_regfile #(.W(W), .N(N), .IW(IW)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .widx    (widx),
        .wdata   (wdata),
        .ra_idx  (dst_i),
        .ra_data (opa),
        .rb_idx  (src_i),
        .rb_data (opb_reg)
    );

    assign opb = use_imm_i ? imm_i : opb_reg;

    xu_alu #(.W(W)) u_alu (
        .op (xu_op_e'(op_i)),
        .a  (opa),
        .b  (opb),
        .y  (alu_y)
    );

    always_comb begin
        ctl.accept   = valid_i && !div_busy;
        ctl.known    = op_known(op_i);
        ctl.to_zero  = (dst_i == '0);
        ctl.is_div   = (op_i == OP_DIV);
        ctl.div_zero = (opb == '0);
    end

    assign go        = ctl.accept && ctl.known && !ctl.to_zero;
    assign div_start = go && ctl.is_div && !ctl.div_zero;
    assign quick     = go && !(ctl.is_div && !ctl.div_zero);
    assign quick_val = ctl.is_div ? '1 : alu_y;

    xu_divider #(.W(W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (opa),
        .divisor  (opb),
        .busy     (div_busy),
        .last     (div_last),
        .quot     (div_quot)
    );

    // Write port: a finishing divide and a quick op never coincide,
    // since quick ops are only accepted while the divider is idle.
    always_comb begin
        we    = 1'b0;
        widx  = dst_i;
        wdata = quick_val;
        if (div_last) begin
            we    = 1'b1;
            widx  = pend_dst_q;
            wdata = div_quot;
        end else if (quick) begin
            we = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q     <= 1'b0;
            illegal_q  <= 1'b0;
            result_q   <= '0;
            pend_dst_q <= '0;
        end else begin
            done_q    <= we;
            illegal_q <= ctl.accept && ctl.known && ctl.to_zero;
            if (we)
                result_q <= wdata;
            if (div_start)
                pend_dst_q <= dst_i;
        end
    end

    assign busy_o    = div_busy;
    assign done_o    = done_q;
    assign illegal_o = illegal_q;
    assign result_o  = result_q;
endmodule

// File: rtl/xu_exec_chk.sv
module xu_exec_chk #(
    parameter int W  = 64,
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          valid_i,
    input logic [3:0]    op_i,
    input logic [IW-1:0] dst_i,
    input logic          use_imm_i,
    input logic [W-1:0]  imm_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          illegal_o,
    input logic [W-1:0]  result_o
);
    AST_ZERO_REFUSED: assert property (@(posedge clk) disable iff (rst)
        valid_i && !busy_o && op_i <= 4'd9 && dst_i == '0 |=> illegal_o && !done_o); // R3
    AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> $past(valid_i && dst_i == '0)); // R3
    AST_QUICK_DONE: assert property (@(posedge clk) disable iff (rst)
        valid_i && !busy_o && op_i <= 4'd9 && op_i != 4'd7 && dst_i != '0 |=> done_o); // R8
    AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !done_o); // R9
    AST_BUSY_FROM_DIV: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(valid_i && op_i == 4'd7)); // R9
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        busy_o && valid_i |=> !illegal_o); // R10
    AST_DIVZERO_ONES: assert property (@(posedge clk) disable iff (rst)
        valid_i && !busy_o && op_i == 4'd7 && use_imm_i && imm_i == '0 && dst_i != '0
        |=> done_o && result_o == '1 && !busy_o); // R11
    AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (rst)
        valid_i && !busy_o && op_i > 4'd9 |=> !done_o && !illegal_o); // R12
endmodule

bind xu_exec_unit xu_exec_chk #(.W(W), .IW(IW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .dst_i     (dst_i),
    .use_imm_i (use_imm_i),
    .imm_i     (imm_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .illegal_o (illegal_o),
    .result_o  (result_o)
);

// File: tb/tb_xu_exec_unit.sv
`timescale 1ns/1ps
module tb_xu_exec_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [3:0]  dst_i = '0;
    logic [3:0]  src_i = '0;
    logic        use_imm_i = 1'b0;
    logic [63:0] imm_i = '0;
    logic        busy_o, done_o, illegal_o;
    logic [63:0] result_o;

    int n_run = 0;
    int n_fail = 0;
    int n_done = 0;

    always #2.5 clk = ~clk;

    xu_exec_unit dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .dst_i(dst_i),
        .src_i(src_i), .use_imm_i(use_imm_i), .imm_i(imm_i),
        .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o), .result_o(result_o)
    );

    always @(posedge clk) if (done_o) n_done++;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  dst;
        logic [3:0]  src;
        logic        sel;
        logic [63:0] imm;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{4'd0, 4'd1, 4'd0, 1'b1, 64'd5,                 64'd5},                 // R4 mov
        '{4'd1, 4'd1, 4'd0, 1'b1, 64'd1,                 64'd1},                 // R4 and
        '{4'd0, 4'd2, 4'd0, 1'b1, 64'hF0F0,              64'hF0F0},              // R4
        '{4'd2, 4'd2, 4'd1, 1'b0, 64'hDEAD,              64'hF0F1},              // R7 reg operand
        '{4'd3, 4'd2, 4'd0, 1'b1, 64'hFFFF,              64'h0F0E},              // R4 xor
        '{4'd0, 4'd3, 4'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        '{4'd4, 4'd3, 4'd1, 1'b0, 64'd0,                 64'd0},                 // R5 add wrap
        '{4'd9, 4'd3, 4'd2, 1'b1, 64'd7,                 64'hFFFF_FFFF_FFFF_FFFF}, // R6 dec
        '{4'd8, 4'd3, 4'd2, 1'b0, 64'd9,                 64'd0},                 // R6 inc
        '{4'd0, 4'd4, 4'd0, 1'b1, 64'h1_0000_0000,       64'h1_0000_0000},
        '{4'd6, 4'd4, 4'd4, 1'b0, 64'd0,                 64'd0},                 // R5 mul wrap
        '{4'd0, 4'd5, 4'd0, 1'b1, 64'd7,                 64'd7},
        '{4'd5, 4'd5, 4'd0, 1'b1, 64'd9,                 64'hFFFF_FFFF_FFFF_FFFE}, // R5 sub wrap
        '{4'd0, 4'd6, 4'd0, 1'b1, 64'd3,                 64'd3},
        '{4'd0, 4'd6, 4'd0, 1'b0, 64'd77,                64'd0},                 // R2 x0 source
        '{4'd6, 4'd5, 4'd0, 1'b1, 64'd3,                 64'hFFFF_FFFF_FFFF_FFFA}, // R5 mul
        '{4'd4, 4'd15, 4'd0, 1'b1, 64'h123,              64'h123}                // R1 x15 from reset
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] op, input logic [3:0] dst, input logic [3:0] src,
                        input logic sel, input logic [63:0] imm);
        @(negedge clk);
        op_i = op; dst_i = dst; src_i = src; use_imm_i = sel; imm_i = imm;
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    // Non-destructive read: or xN with immediate zero
    task automatic read_reg(input logic [3:0] idx, output logic [63:0] val);
        send(4'd2, idx, 4'd0, 1'b1, 64'd0);
        val = result_o;
    endtask

    task automatic wait_div(output int cyc);
        cyc = 0;
        while (!done_o && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] v;
        int cyc;
        int d0;
        repeat (3) @(negedge clk);
        check("R1 busy after reset", {63'd0, busy_o}, 64'd0);
        check("R1 done after reset", {63'd0, done_o}, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            send(VEC[i].op, VEC[i].dst, VEC[i].src, VEC[i].sel, VEC[i].imm);
            check($sformatf("R8 vector %0d done", i), {63'd0, done_o}, 64'd1);
            check($sformatf("R4/R5/R6 vector %0d result", i), result_o, VEC[i].exp);
        end

        // R9: unsigned divide by immediate, latency and busy
        send(4'd0, 4'd7, 4'd0, 1'b1, 64'd1000);
        send(4'd7, 4'd7, 4'd0, 1'b1, 64'd7);
        check("R9 busy after start", {63'd0, busy_o}, 64'd1);
        wait_div(cyc);
        check("R9 divide latency", 64'(cyc), 64'd64);
        check("R9 quotient", result_o, 64'd142);
        check("R9 busy low at done", {63'd0, busy_o}, 64'd0);

        // R9: unsigned (large dividend) with register divisor
        send(4'd0, 4'd8, 4'd0, 1'b1, 64'h100);
        send(4'd7, 4'd5, 4'd8, 1'b0, 64'd0);
        wait_div(cyc);
        check("R9 unsigned quotient", result_o, 64'h00FF_FFFF_FFFF_FFFF);

        // R11: divide by zero, immediate and x0 register
        send(4'd7, 4'd7, 4'd0, 1'b1, 64'd0);
        check("R11 imm zero done", {62'd0, busy_o, done_o}, 64'd1);
        check("R11 imm zero result", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
        send(4'd7, 4'd1, 4'd0, 1'b0, 64'd5);
        check("R11 reg zero result", result_o, 64'hFFFF_FFFF_FFFF_FFFF);

        // R10: request during a divide is dropped
        send(4'd0, 4'd7, 4'd0, 1'b1, 64'd100);
        send(4'd7, 4'd7, 4'd0, 1'b1, 64'd3);
        d0 = n_done;
        repeat (10) @(negedge clk);
        send(4'd0, 4'd9, 4'd0, 1'b1, 64'd55);
        check("R10 no illegal/done while busy", {62'd0, illegal_o, done_o}, 64'd0);
        wait_div(cyc);
        check("R10 quotient", result_o, 64'd33);
        @(negedge clk);
        check("R10 single done", 64'(n_done - d0), 64'd1);
        read_reg(4'd9, v);
        check("R10 x9 untouched", v, 64'd0);

        // R3: write to x0 refused
        send(4'd0, 4'd0, 4'd0, 1'b1, 64'd5);
        check("R3 illegal pulse", {62'd0, illegal_o, done_o}, 64'd2);
        @(negedge clk);
        check("R3 illegal one cycle", {63'd0, illegal_o}, 64'd0);
        send(4'd0, 4'd10, 4'd0, 1'b0, 64'd9);
        check("R2 R3 x0 still zero", result_o, 64'd0);

        // R12: unknown opcode ignored
        send(4'd0, 4'd11, 4'd0, 1'b1, 64'd44);
        send(4'd12, 4'd11, 4'd0, 1'b1, 64'd99);
        check("R12 no done/illegal", {62'd0, illegal_o, done_o}, 64'd0);
        read_reg(4'd11, v);
        check("R12 x11 unchanged", v, 64'd44);

        // R1: reset mid-run clears registers
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 flags after reset", {61'd0, busy_o, illegal_o, done_o}, 64'd0);
        read_reg(4'd5, v);
        check("R1 x5 cleared", v, 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule